// File: doc/BRIEF.md
# Configurable GPIO Port with Change Interrupt

This block is an eight-pin general-purpose I/O port run from a small bank of byte-wide registers. A host-side serial slave turns bus transactions into register read and write strobes. The port turns the register contents into a drive value and a drive enable for each pad. Each pin is either an input or an output. Each output drives either both levels or only low. When fan mode is on, the upper four pins are taken over and driven low-only from a fan-speed register, whatever the direction register holds.

Input pins can latch a status bit when their synchronised level changes. With the global interrupt enable set, a latched change pulls an active-low alert line low. The alert line is released when the host reads the status register or when the serial slave signals that an alert-response cycle has completed. Writing the status register has no effect on the alert line.

The register port is a plain strobe interface. It accepts a read or a write on every clock and never applies back-pressure. Read data comes back with a one-cycle valid pulse.

Top module: `gpio_expander_core`

## Requirements
- R1: After reset every register reads 00h, every pin has its output enable off, and `alert_n` is high.
- R2: Command 00h is the configuration register. Bit 0 is the global interrupt enable and bit 1 selects fan mode. Bits 7 to 2 always read 0, whatever was written.
- R3: Command 01h holds one direction bit per pin, where 1 means output. A push-pull output pin has its output enable on and drives the value held in its data latch.
- R4: Command 02h holds one drive-type bit per pin, where 1 means open-drain. An open-drain output drives low with its output enable on when its latch is 0, and turns its output enable off when its latch is 1. It never drives high.
- R5: A write to command 03h sets the data latch. A read of 03h returns the latch bit for pins acting as outputs and the `pin_in` level for all other pins.
- R6: Command 06h holds a 3-bit fan speed (bits 2:0; bits 7:3 read 0). In fan mode, pins 7 to 4 are open-drain outputs regardless of the direction register. Pin 4 is pulled low only when the speed is 0. Pin 5+k is pulled low when speed bit k is 1.
- R7: Command 04h is a per-pin change mask. A status bit is set when its pin is acting as an input, its mask bit is 1, and `pin_in` differs from the sample taken one clock earlier. Output pins, fan-owned pins and unmasked pins never set status.
- R8: A read of command 05h returns the latched status and clears it. Status bits otherwise stay set. A change that arrives on the same clock as the read is kept for the next read.
- R9: With the interrupt enable set, `alert_n` goes low on the clock after the first latched change. With the enable clear, status still latches but `alert_n` stays high.
- R10: `alert_n` returns high after a read of 05h or a one-cycle `ara_clr` pulse. `ara_clr` leaves status intact, and a write to 05h changes neither status nor `alert_n`.
- R11: `reg_rvalid` is high on exactly the clock after each `reg_rd`, with `reg_rdata` alongside. Commands 07h and above read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Command code selecting the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | One-cycle pulse after a read strobe |
| pin_in | input | 8 | Synchronised pad levels |
| pin_out | output | 8 | Per-pin drive value |
| pin_oe | output | 8 | Per-pin drive enable |
| ara_clr | input | 1 | Alert-response completion pulse |
| alert_n | output | 1 | Active-low alert; drive low when 0, release when 1 |

## Verification
The assertions assume that `pin_in` has already been synchronised to `clk` and that `reg_rd` and `reg_wr` are never high in the same cycle. They also assume `ara_clr` is a single-cycle pulse from the serial slave. The bench changes `pin_in` and the strobes only on falling edges. It issues either a read or a write in a cycle, never both, and keeps each `ara_clr` pulse to one clock. This keeps every stimulus inside those assumptions.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_CFG  = 8'h00;
  localparam logic [CMD_W-1:0] CMD_DIR  = 8'h01;
  localparam logic [CMD_W-1:0] CMD_DRV  = 8'h02;
  localparam logic [CMD_W-1:0] CMD_DATA = 8'h03;
  localparam logic [CMD_W-1:0] CMD_MASK = 8'h04;
  localparam logic [CMD_W-1:0] CMD_STAT = 8'h05;
  localparam logic [CMD_W-1:0] CMD_FAN  = 8'h06;

  localparam int CFG_IE_BIT  = 0;
  localparam int CFG_FAN_BIT = 1;

  typedef struct packed {
    logic fan;
    logic ie;
  } cfg_t;
endpackage

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int FAN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [CMD_W-1:0] addr,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] latch_role,
  input  logic [NPINS-1:0] status,
  output cfg_t             cfg,
  output logic [NPINS-1:0] dir,
  output logic [NPINS-1:0] drv_od,
  output logic [NPINS-1:0] latch,
  output logic [NPINS-1:0] mask,
  output logic [FAN_W-1:0] fan_speed,
  output logic [NPINS-1:0] rdata,
  output logic             rvalid,
  output logic             status_rd
);
  logic [NPINS-1:0] rd_mux;

  assign status_rd = rd && (addr == CMD_STAT);

  always_comb begin
    rd_mux = '0;
    case (addr)
      CMD_CFG: begin
        rd_mux[CFG_IE_BIT]  = cfg.ie;
        rd_mux[CFG_FAN_BIT] = cfg.fan;
      end
      CMD_DIR:  rd_mux = dir;
      CMD_DRV:  rd_mux = drv_od;
      CMD_DATA: rd_mux = (latch & latch_role) | (pin_in & ~latch_role);
      CMD_MASK: rd_mux = mask;
      CMD_STAT: rd_mux = status;
      CMD_FAN:  rd_mux = NPINS'(fan_speed);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      dir       <= '0;
      drv_od    <= '0;
      latch     <= '0;
      mask      <= '0;
      fan_speed <= '0;
      rdata     <= '0;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
      if (wr) begin
        case (addr)
          CMD_CFG: begin
            cfg.ie  <= wdata[CFG_IE_BIT];
            cfg.fan <= wdata[CFG_FAN_BIT];
          end
          CMD_DIR:  dir       <= wdata;
          CMD_DRV:  drv_od    <= wdata;
          CMD_DATA: latch     <= wdata;
          CMD_MASK: mask      <= wdata;
          CMD_FAN:  fan_speed <= wdata[FAN_W-1:0];
          default: ;
        endcase
      end
    end
  end

  p_rvalid_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  p_rvalid_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
endmodule

// File: rtl/gpx_pad_ctrl.sv
module gpx_pad_ctrl #(
  parameter int NPINS = 8,
  parameter int FAN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fan_en,
  input  logic [FAN_W-1:0] fan_speed,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] drv_od,
  input  logic [NPINS-1:0] latch,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] in_role,
  output logic [NPINS-1:0] latch_role
);
  localparam int FAN_LSB = NPINS - FAN_W - 1;

  logic [NPINS-1:0] fan_role, fan_lvl, od_eff, out_en, lvl;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i < FAN_LSB) begin : g_plain
      assign fan_role[i] = 1'b0;
      assign fan_lvl[i]  = 1'b0;
    end else if (i == FAN_LSB) begin : g_shdn
      assign fan_role[i] = fan_en;
      assign fan_lvl[i]  = |fan_speed;
    end else begin : g_speed
      assign fan_role[i] = fan_en;
      assign fan_lvl[i]  = ~fan_speed[i-FAN_LSB-1];
    end
  end

  assign od_eff     = fan_role | drv_od;
  assign out_en     = fan_role | dir;
  assign lvl        = (fan_role & fan_lvl) | (~fan_role & latch);
  assign pin_out    = lvl & ~od_eff;
  assign pin_oe     = out_en & (~od_eff | ~lvl);
  assign in_role    = ~out_en;
  assign latch_role = dir & ~fan_role;

  p_od_never_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_out & drv_od) == '0);
  p_fan_pins_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fan_en |-> ((pin_oe[NPINS-1:FAN_LSB] & pin_out[NPINS-1:FAN_LSB]) == '0));
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] in_role,
  input  logic [NPINS-1:0] mask,
  input  logic             ie,
  input  logic             status_rd,
  input  logic             ara_clr,
  output logic [NPINS-1:0] status,
  output logic             alert_n
);
  logic [NPINS-1:0] prev, evt;
  logic             pend;

  assign evt     = (pin_in ^ prev) & in_role & mask;
  assign alert_n = ~pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= '0;
      status <= '0;
      pend   <= 1'b0;
    end else begin
      prev   <= pin_in;
      status <= (status_rd ? '0 : status) | evt;
      if (ie && (evt != '0))         pend <= 1'b1;
      else if (status_rd || ara_clr) pend <= 1'b0;
    end
  end

  p_alert_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(ie));
  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_rd && evt == '0) |=> status == $past(status));
  p_ara_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_clr && !(ie && evt != '0)) |=> alert_n);
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
  import gpx_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int FAN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [CMD_W-1:0] reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  output logic             reg_rvalid,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic             ara_clr,
  output logic             alert_n
);
  cfg_t             cfg;
  logic [NPINS-1:0] dir, drv_od, latch, mask, status, in_role, latch_role;
  logic [FAN_W-1:0] fan_speed;
  logic             status_rd;

  gpx_regs #(.NPINS(NPINS), .FAN_W(FAN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .pin_in(pin_in), .latch_role(latch_role), .status(status),
    .cfg(cfg), .dir(dir), .drv_od(drv_od), .latch(latch), .mask(mask),
    .fan_speed(fan_speed), .rdata(reg_rdata), .rvalid(reg_rvalid),
    .status_rd(status_rd)
  );

  gpx_pad_ctrl #(.NPINS(NPINS), .FAN_W(FAN_W)) u_pads (
    .clk(clk), .rst_n(rst_n), .fan_en(cfg.fan), .fan_speed(fan_speed),
    .dir(dir), .drv_od(drv_od), .latch(latch), .pin_out(pin_out),
    .pin_oe(pin_oe), .in_role(in_role), .latch_role(latch_role)
  );

  gpx_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .in_role(in_role), .mask(mask),
    .ie(cfg.ie), .status_rd(status_rd), .ara_clr(ara_clr), .status(status),
    .alert_n(alert_n)
  );
endmodule

// File: tb/gpio_expander_core_test.sv
`timescale 1ns/1ps
module gpio_expander_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, ara_clr = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, pin_in = '0;
  logic [7:0] reg_rdata, pin_out, pin_oe;
  logic       reg_rvalid, alert_n;
  int         n_checks = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  gpio_expander_core uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .ara_clr(ara_clr), .alert_n(alert_n)
  );

  // {req[3:0], is_write, addr[7:0], wdata[7:0], expected readback[7:0]}
  localparam int NVEC = 12;
  localparam logic [28:0] VEC [NVEC] = '{
    {4'd2,  1'b1, 8'h00, 8'hFF, 8'h03},  // R2 reserved bits read 0
    {4'd2,  1'b1, 8'h00, 8'h00, 8'h00},  // R2
    {4'd3,  1'b1, 8'h01, 8'hA5, 8'hA5},  // R3
    {4'd4,  1'b1, 8'h02, 8'h3C, 8'h3C},  // R4
    {4'd7,  1'b1, 8'h04, 8'h0F, 8'h0F},  // R7 mask readback
    {4'd6,  1'b1, 8'h06, 8'hFF, 8'h07},  // R6 speed is 3 bits
    {4'd10, 1'b1, 8'h05, 8'hFF, 8'h00},  // R10 status write ignored
    {4'd11, 1'b1, 8'h07, 8'h55, 8'h00},  // R11
    {4'd11, 1'b1, 8'hFF, 8'hAA, 8'h00},  // R11
    {4'd5,  1'b1, 8'h03, 8'hF0, 8'hA0},  // R5 latch on outputs, pins elsewhere
    {4'd3,  1'b0, 8'h01, 8'h00, 8'hA5},  // R3 value kept
    {4'd6,  1'b0, 8'h06, 8'h00, 8'h07}   // R6 value kept
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pin_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    #1;
    d = reg_rvalid ? reg_rdata : 8'hXX;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    do_reset();

    // R1: reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 alert_n", {7'd0, alert_n}, 8'h01);
    for (int a = 0; a < 7; a++) begin
      do_read(8'(a), rv);
      check("R1 register", rv, 8'h00);
    end

    // Table walk: write then read back
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][24]) do_write(VEC[i][23:16], VEC[i][15:8]);
      do_read(VEC[i][23:16], rv);
      n_checks++;
      if (rv !== VEC[i][7:0]) begin
        n_fail++;
        $display("FAIL R%0d table %0d: actual %02h expected %02h",
                 VEC[i][28:25], i, rv, VEC[i][7:0]);
      end
    end

    // R3 R4: pad drive
    do_reset();
    do_write(8'h01, 8'hFF);
    do_write(8'h02, 8'h0F);
    do_write(8'h03, 8'h55);
    #1;
    check("R3/R4 pin_oe", pin_oe, 8'hFA);
    check("R3/R4 pin_out", pin_out, 8'h50);

    // R5: data readback mix
    do_write(8'h01, 8'h0F);
    pin_in = 8'hC3;
    do_read(8'h03, rv);
    check("R5 data read", rv, 8'hC5);

    // R6: fan mode overrides direction
    pin_in = 8'h00;
    do_write(8'h06, 8'h05);
    do_write(8'h00, 8'h02);
    #1;
    check("R6 pin_oe speed 5", pin_oe, 8'hAA);
    check("R6 pin_out speed 5", pin_out, 8'h00);
    do_write(8'h06, 8'h00);
    #1;
    check("R6 pin_oe speed 0", pin_oe, 8'h1A);

    // R7 R9 R8 R10: change interrupt
    do_reset();
    do_write(8'h04, 8'hFF);
    do_write(8'h01, 8'h0F);
    do_write(8'h00, 8'h01);
    pin_in = 8'h30;
    @(negedge clk); #1;
    check("R9 alert low", {7'd0, alert_n}, 8'h00);
    do_read(8'h05, rv);
    check("R8 status read", rv, 8'h30);
    check("R10 alert released by read", {7'd0, alert_n}, 8'h01);
    do_read(8'h05, rv);
    check("R8 status cleared", rv, 8'h00);

    pin_in = 8'h31;  // bit 0 is an output pin
    idle(2);
    do_read(8'h05, rv);
    check("R7 output pin ignored", rv, 8'h00);

    // R9: enable off
    do_write(8'h00, 8'h00);
    pin_in = 8'h71;
    idle(2); #1;
    check("R9 no alert when disabled", {7'd0, alert_n}, 8'h01);
    do_read(8'h05, rv);
    check("R9 status still latches", rv, 8'h40);

    // R10: ara clear, status write ignored
    do_write(8'h00, 8'h01);
    pin_in = 8'hF1;
    idle(1);
    do_write(8'h05, 8'h00);
    #1;
    check("R10 status write keeps alert", {7'd0, alert_n}, 8'h00);
    ara_clr = 1'b1;
    @(negedge clk);
    ara_clr = 1'b0;
    #1;
    check("R10 ara clears alert", {7'd0, alert_n}, 8'h01);
    do_read(8'h05, rv);
    check("R10 ara keeps status", rv, 8'h80);

    // R8: event on the same clock as a status read
    pin_in = 8'hB1;
    reg_addr = 8'h05; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    #1;
    check("R8 coincident read old", reg_rdata, 8'h00);
    do_read(8'h05, rv);
    check("R8 coincident event kept", rv, 8'h40);

    // R7: unmasked pin
    do_write(8'h04, 8'h0F);
    pin_in = 8'h31;
    idle(2);
    do_read(8'h05, rv);
    check("R7 unmasked ignored", rv, 8'h00);

    // R7: fan-owned pins never set status
    do_write(8'h04, 8'hFF);
    do_write(8'h00, 8'h03);
    pin_in = 8'h11;
    idle(2);
    do_read(8'h05, rv);
    check("R7 fan pins ignored", rv, 8'h00);
    check("R7 no alert from fan pins", {7'd0, alert_n}, 8'h01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule